// File: doc/BRIEF.md
# Register-Written Serial Transmitter

This block is a transmit-only asynchronous serial port that hangs off the special-function-register write bus of a small 8-bit controller core. Software stores one byte into the transmit register, and the block immediately sends that byte on a single output line. The byte goes out as one low start bit, eight data bits with the least significant bit first, and one high stop bit. No separate start command is needed, because the register write itself starts the frame.

Bit timing comes from a down-counter that runs in the system clock domain. The counter produces a one-cycle enable at every bit boundary. No derived clock drives any flop. The divisor is a compile-time parameter, so it can later be replaced by a register without changing the timing structure. The write strobe is sampled as a level on the system clock edge.

The two state bits of the transmit controller are brought out as outputs for debug. A busy flag shows when a frame is in progress. Writes that arrive while busy is high are discarded.

Top module: `sfr_uart_tx`

## Requirements
- R1: While reset is asserted and on release, `txd` is 1, `busy` is 0 and `tx_state` is 2'b00.
- R2: A clock edge that samples `sfr_we`=1 with `sfr_addr`=8'h91 while idle latches `sfr_wdata`. From that edge on, `busy` is 1 and `txd` carries the start bit.
- R3: A write to any address other than 8'h91 has no effect: `txd` stays 1, `busy` stays 0 and `tx_state` stays 2'b00.
- R4: The frame on `txd` is a 0 start bit, then data bits 0 through 7 in that order, then a 1 stop bit.
- R5: Every bit of the frame, start and stop included, lasts exactly DIVISOR clock cycles.
- R6: `busy` stays 1 for exactly 10*DIVISOR cycles after the accepting edge, and then returns to 0.
- R7: A write to 8'h91 while `busy` is 1 is dropped, and the frame in progress is sent unchanged.
- R8: `tx_state` shows the controller state with this encoding: 2'b00 idle, 2'b01 start bit, 2'b10 data bits, 2'b11 stop bit.
- R9: `txd` is 1 whenever the controller is idle, and that includes the time between back-to-back frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all flops use it |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_we | input | 1 | SFR write enable, sampled on the clock edge |
| sfr_addr | input | 8 | SFR write address |
| sfr_wdata | input | 8 | SFR write data |
| txd | output | 1 | Serial output line, idles high |
| busy | output | 1 | High while a frame is in progress |
| tx_state | output | 2 | Controller state bits for debug |

## Verification
The bench samples each bit at its centre and counts cycles, so it catches a design that reverses the bit order, drops the start or stop bit, or makes a bit one cycle too long or too short. It fires a second write to the data register in the middle of a frame. A design that accepts that write would restart the frame or corrupt the byte being sent. It writes to the neighbouring address 8'h90, where a loose decode would start a spurious frame. It also starts a new frame on the very next cycle after busy falls, which exposes a controller that needs an extra idle cycle or that drops the line low early.

// File: rtl/sfr_uart_tx_pkg.sv
package sfr_uart_tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_START = 2'b01,
    ST_DATA  = 2'b10,
    ST_STOP  = 2'b11
  } tx_state_e;

endpackage

// File: rtl/sfr_addr_match.sv
module sfr_addr_match #(
  parameter int          ADDR_W   = 8,
  parameter logic [7:0]  REG_ADDR = 8'h91
) (
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);

  always_comb begin
    hit = we && (addr == ADDR_W'(REG_ADDR));
  end

endmodule

// File: rtl/bit_timer.sv
module bit_timer #(
  parameter int DIVISOR = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  localparam int CW = (DIVISOR > 2) ? $clog2(DIVISOR) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(DIVISOR - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run || cnt_q == '0) begin
      cnt_d = RELOAD;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
    tick = run && (cnt_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= RELOAD;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= RELOAD);

  // R5
  reload_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == RELOAD));

endmodule

// File: rtl/tx_engine.sv
module tx_engine
  import sfr_uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tick,
  output tx_state_e         state,
  output logic              txd
);

  localparam int BW = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

  tx_state_e         state_q, state_d;
  logic [DATA_W-1:0] shreg_q, shreg_d;
  logic [BW-1:0]     bitn_q, bitn_d;
  logic              txd_q, txd_d;

  always_comb begin
    state_d = state_q;
    shreg_d = shreg_q;
    bitn_d  = bitn_q;
    txd_d   = txd_q;
    unique case (state_q)
      ST_IDLE: begin
        txd_d = 1'b1;
        if (wr_hit) begin
          state_d = ST_START;
          shreg_d = wdata;
          txd_d   = 1'b0;
        end
      end
      ST_START: begin
        if (tick) begin
          state_d = ST_DATA;
          bitn_d  = '0;
          txd_d   = shreg_q[0];
        end
      end
      ST_DATA: begin
        if (tick) begin
          if (bitn_q == LAST_BIT) begin
            state_d = ST_STOP;
            txd_d   = 1'b1;
          end else begin
            bitn_d  = bitn_q + 1'b1;
            shreg_d = shreg_q >> 1;
            txd_d   = shreg_q[1];
          end
        end
      end
      ST_STOP: begin
        if (tick) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      shreg_q <= '0;
      bitn_q  <= '0;
      txd_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      shreg_q <= shreg_d;
      bitn_q  <= bitn_d;
      txd_q   <= txd_d;
    end
  end

  assign state = state_q;
  assign txd   = txd_q;

  // R9
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> txd_q);

  // R4
  start_bit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_START) |-> !txd_q);

  // R4
  stop_bit_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STOP) |-> txd_q);

  // R7
  no_restart_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && state_q != ST_IDLE && state_q != ST_START) |=> (state_q != ST_START));

  // R8
  data_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA) |=> (state_q == ST_DATA || state_q == ST_STOP));

endmodule

// File: rtl/sfr_uart_tx.sv
module sfr_uart_tx
  import sfr_uart_tx_pkg::*;
#(
  parameter int         DIVISOR  = 16,
  parameter logic [7:0] REG_ADDR = 8'h91
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sfr_we,
  input  logic [7:0] sfr_addr,
  input  logic [7:0] sfr_wdata,
  output logic       txd,
  output logic       busy,
  output logic [1:0] tx_state
);

  localparam int DATA_W = 8;

  logic      wr_hit;
  logic      tick;
  tx_state_e state;

  sfr_addr_match #(.ADDR_W(8), .REG_ADDR(REG_ADDR)) u_match (
    .we   (sfr_we),
    .addr (sfr_addr),
    .hit  (wr_hit)
  );

  bit_timer #(.DIVISOR(DIVISOR)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy),
    .tick  (tick)
  );

  tx_engine #(.DATA_W(DATA_W)) u_engine (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_hit (wr_hit),
    .wdata  (sfr_wdata),
    .tick   (tick),
    .state  (state),
    .txd    (txd)
  );

  assign busy     = (state != ST_IDLE);
  assign tx_state = state;

  // R2
  accept_starts_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !busy) |=> (busy && !txd));

  // R3
  foreign_addr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(sfr_we && sfr_addr == REG_ADDR)) |=> !busy);

endmodule

// File: tb/tb_sfr_uart_tx.sv
`timescale 1ns/1ps
module tb_sfr_uart_tx;

  localparam int D = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sfr_we = 1'b0;
  logic [7:0] sfr_addr = 8'h00;
  logic [7:0] sfr_wdata = 8'h00;
  logic       txd;
  logic       busy;
  logic [1:0] tx_state;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sfr_uart_tx #(.DIVISOR(D), .REG_ADDR(8'h91)) dut (
    .clk(clk), .rst_n(rst_n), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .txd(txd), .busy(busy), .tx_state(tx_state)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 txd", txd, 1);
    chk("R1 busy", busy, 0);
    chk("R1 state", tx_state, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 txd after release", txd, 1);
    chk("R1 state after release", tx_state, 0);
  endtask

  // Sends a byte and checks frame, timing, busy and state; optional write mid-frame (R7)
  task automatic t_frame(input logic [7:0] data, input bit inject);
    logic [9:0] bits;
    int busy_bad = 0;
    sfr_we = 1'b1; sfr_addr = 8'h91; sfr_wdata = data;
    for (int j = 0; j < 10*D; j++) begin
      @(negedge clk);
      if (j == 0) begin
        sfr_we = 1'b0;
        chk("R2 busy after accept", busy, 1);
        chk("R2 start bit", txd, 0);
        chk("R8 start state", tx_state, 2'b01);
      end
      if (inject && j == 3*D) begin
        sfr_we = 1'b1; sfr_addr = 8'h91; sfr_wdata = ~data;
      end
      if (inject && j == 3*D + 1) sfr_we = 1'b0;
      if (j == D) chk("R8 data state", tx_state, 2'b10);
      if (j == 9*D) chk("R8 stop state", tx_state, 2'b11);
      if (j % D == D/2) bits[j/D] = txd;
      if (j % D == 0 && j > 0 && j/D < 9) begin
        chk("R5 bit edge", txd, data[j/D - 1]);
      end
      if (busy !== 1'b1) busy_bad++;
    end
    chk("R4 start", bits[0], 0);
    chk(inject ? "R7 data unchanged" : "R4 data lsb first", bits[8:1], data);
    chk("R4 stop", bits[9], 1);
    chk("R6 busy held", busy_bad, 0);
    @(negedge clk);
    chk("R6 busy released", busy, 0);
    chk("R9 line idle", txd, 1);
    chk("R8 idle state", tx_state, 2'b00);
  endtask

  task automatic t_wrong_addr();
    int bad = 0;
    sfr_we = 1'b1; sfr_addr = 8'h90; sfr_wdata = 8'h00;
    @(negedge clk);
    sfr_we = 1'b0;
    for (int j = 0; j < 3*D; j++) begin
      if (txd !== 1'b1 || busy !== 1'b0 || tx_state !== 2'b00) bad++;
      @(negedge clk);
    end
    chk("R3 foreign address ignored", bad, 0);
  endtask

  initial begin
    t_reset();
    t_frame(8'hA5, 1'b0);
    t_wrong_addr();
    t_frame(8'h01, 1'b0);
    t_frame(8'h80, 1'b0);   // back-to-back, no gap (R9)
    t_frame(8'h3C, 1'b1);
    t_frame(8'hFF, 1'b0);
    t_frame(8'h00, 1'b0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule